// File: doc/BRIEF.md
# Pipelined 8-bit Accumulator Processor Core

This core runs one instruction per clock from an external program memory of 16-bit words. Each word holds an opcode byte in its upper half and an immediate data byte in its lower half. On every edge the core latches the word addressed by the program counter into an opcode register and a data register. In the same cycle it executes the word it latched one cycle earlier. Fetch and execute therefore overlap, and the word that follows any jump always executes before the jump lands.

The opcode byte has three fields. Bits 7:5 give the operation, bits 4:2 give the mode, and bits 1:0 give the bus source. The mode chooses how the data-memory address is built from the immediate, X and Y, and which register receives the result: the accumulator, X, Y or the output register. For jumps, the mode instead selects either a far jump or a condition mask that is tested against the accumulator's sign and zero state. Data memory, the program memory and the input pins are outside the block. The core drives an address and reads the returned data in the same cycle.

Top module: `acc8_core`

## Requirements
- R1: While `rst` is high, every clock edge sets the program counter (`rom_addr`) to 0.
- R2: An instruction word fetched at the same time as a jump executes in full, and execution then continues at the jump target.
- R3: Operation codes 0 to 5 give: 0 load bus, 1 AC AND bus, 2 AC OR bus, 3 AC XOR bus, 4 AC plus bus, 5 AC minus bus. Addition and subtraction wrap modulo 256.
- R4: Bus source code 0 selects the immediate byte, 1 selects `ram_rdata`, 2 selects AC and 3 selects `in_port`.
- R5: Modes 0 to 3 write AC. Their addresses are {0,imm}, {0,X}, {Y,imm} and {Y,X} respectively, with the high byte first.
- R6: Mode 4 writes X and mode 5 writes Y, both at address {0,imm}. Mode 6 writes the output register at {0,imm}. Mode 7 writes the output register at {Y,X} and then increments X modulo 256.
- R7: Operation 6 (store) raises `ram_we` for one cycle. It drives the bus value on `ram_wdata` and the low 15 bits of the address on `ram_addr`. No other operation raises `ram_we`.
- R8: A store leaves AC and the output register unchanged. In modes 4 and 5 it still loads X or Y with AC.
- R9: Operation 7 with mode 0 sets the program counter to {Y, bus}.
- R10: Operation 7 with a nonzero mode tests one mode bit. Bit 0 is tested when AC is positive and nonzero, bit 1 when AC bit 7 is set, and bit 2 when AC is zero. If the tested bit is set, the jump is taken to {PC[15:8], bus}. Otherwise the program counter steps.
- R11: When no jump is taken, the program counter increments by one modulo 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the program counter |
| rom_addr | output | 16 | Program counter, the fetch address |
| rom_data | input | 16 | Program word: opcode in bits 15:8, immediate in bits 7:0 |
| ram_addr | output | 15 | Data-memory address for the instruction now executing |
| ram_rdata | input | 8 | Data-memory read value for `ram_addr` |
| ram_wdata | output | 8 | Store data (bus value) |
| ram_we | output | 1 | Store strobe, written at the next clock edge |
| in_port | input | 8 | Input pins, bus source 3 |
| out_port | output | 8 | Output register |

## Verification
Properties are checked on every cycle:
- The program counter clears under reset and steps by one after each non-jump.
- A far jump takes its high byte from Y, and a conditional jump either keeps the current page or steps.
- X advances in mode 7, and AC and the output register hold across a store.
- The store strobe only appears for operation 6, and the zero-page modes never drive high address bits.

The bench scenarios are the only way to show the actual data values. These include the ALU results with wraparound, each bus source and the register-indexed addresses. They also show that exactly the delay-slot word executes after each kind of jump, and that each condition mask is taken or not taken as expected.

// File: rtl/acc8_pkg.sv
`timescale 1ns/1ps
package acc8_pkg;

    typedef enum logic [2:0] {
        OP_LD  = 3'd0,
        OP_AND = 3'd1,
        OP_OR  = 3'd2,
        OP_XOR = 3'd3,
        OP_ADD = 3'd4,
        OP_SUB = 3'd5,
        OP_ST  = 3'd6,
        OP_JMP = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        SRC_IMM = 2'd0,
        SRC_RAM = 2'd1,
        SRC_ACC = 2'd2,
        SRC_INP = 2'd3
    } src_e;

    typedef enum logic [2:0] {
        DST_NONE,
        DST_ACC,
        DST_XR,
        DST_YR,
        DST_OUT
    } dst_e;

    // next-PC choice, evaluated every cycle
    typedef enum logic [1:0] {
        PCS_SEQ,
        PCS_FAR,
        PCS_NEAR
    } pcsel_e;

    typedef struct packed {
        op_e        op;
        logic [2:0] mode;
        src_e       src;
        dst_e       dst;
        logic       lo_from_x;
        logic       hi_from_y;
        logic       x_incr;
        logic       mem_we;
    } dec_t;

endpackage

// File: rtl/acc8_decode.sv
`timescale 1ns/1ps
module acc8_decode
    import acc8_pkg::*;
(
    input  logic [7:0] opcode,
    output dec_t       dec
);

    always_comb begin
        dec           = '0;
        dec.op        = op_e'(opcode[7:5]);
        dec.mode      = opcode[4:2];
        dec.src       = src_e'(opcode[1:0]);
        dec.mem_we    = (dec.op == OP_ST);
        dec.dst       = DST_NONE;
        dec.lo_from_x = 1'b0;
        dec.hi_from_y = 1'b0;
        dec.x_incr    = 1'b0;

        if (dec.op != OP_JMP) begin
            unique case (dec.mode)
                3'd0: dec.dst = DST_ACC;
                3'd1: begin
                    dec.dst       = DST_ACC;
                    dec.lo_from_x = 1'b1;
                end
                3'd2: begin
                    dec.dst       = DST_ACC;
                    dec.hi_from_y = 1'b1;
                end
                3'd3: begin
                    dec.dst       = DST_ACC;
                    dec.lo_from_x = 1'b1;
                    dec.hi_from_y = 1'b1;
                end
                3'd4: dec.dst = DST_XR;
                3'd5: dec.dst = DST_YR;
                3'd6: dec.dst = DST_OUT;
                3'd7: begin
                    dec.dst       = DST_OUT;
                    dec.lo_from_x = 1'b1;
                    dec.hi_from_y = 1'b1;
                    dec.x_incr    = 1'b1;
                end
            endcase
        end

        // a store keeps AC and OUT, but X/Y still load
        if (dec.mem_we && (dec.dst == DST_ACC || dec.dst == DST_OUT)) begin
            dec.dst = DST_NONE;
        end
    end

endmodule

// File: rtl/acc8_alu.sv
`timescale 1ns/1ps
module acc8_alu
    import acc8_pkg::*;
#(
    parameter int W = 8
) (
    input  op_e          op,
    input  logic [W-1:0] acc,
    input  logic [W-1:0] bus,
    output logic [W-1:0] result
);

    always_comb begin
        unique case (op)
            OP_LD:   result = bus;
            OP_AND:  result = acc & bus;
            OP_OR:   result = acc | bus;
            OP_XOR:  result = acc ^ bus;
            OP_ADD:  result = acc + bus;
            OP_SUB:  result = acc - bus;
            OP_ST:   result = acc;
            OP_JMP:  result = '0 - acc;
            default: result = bus;
        endcase
    end

endmodule

// File: rtl/acc8_pc_next.sv
`timescale 1ns/1ps
module acc8_pc_next
    import acc8_pkg::*;
#(
    parameter int W    = 8,
    parameter int PC_W = 2 * W
) (
    input  op_e             op,
    input  logic [2:0]      mode,
    input  logic [PC_W-1:0] pc,
    input  logic [W-1:0]    acc,
    input  logic [W-1:0]    yr,
    input  logic [W-1:0]    bus,
    output pcsel_e          sel,
    output logic [PC_W-1:0] pc_nxt
);

    logic acc_zero;
    logic acc_neg;
    logic acc_pos;
    logic taken;

    assign acc_zero = (acc == '0);
    assign acc_neg  = acc[W-1];
    assign acc_pos  = !acc_zero && !acc_neg;
    assign taken    = (mode[0] && acc_pos) || (mode[1] && acc_neg) || (mode[2] && acc_zero);

    always_comb begin
        sel = PCS_SEQ;
        if (op == OP_JMP) begin
            if (mode == 3'd0) begin
                sel = PCS_FAR;
            end else if (taken) begin
                sel = PCS_NEAR;
            end
        end
    end

    always_comb begin
        unique case (sel)
            PCS_SEQ:  pc_nxt = pc + 1'b1;
            PCS_FAR:  pc_nxt = {yr, bus};
            PCS_NEAR: pc_nxt = {pc[PC_W-1:W], bus};
            default:  pc_nxt = pc + 1'b1;
        endcase
    end

endmodule

// File: rtl/acc8_core.sv
`timescale 1ns/1ps
module acc8_core
    import acc8_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PC_W   = 2 * DATA_W,
    parameter int RAM_AW = 15
) (
    input  logic                clk,
    input  logic                rst,
    output logic [PC_W-1:0]     rom_addr,
    input  logic [2*DATA_W-1:0] rom_data,
    output logic [RAM_AW-1:0]   ram_addr,
    input  logic [DATA_W-1:0]   ram_rdata,
    output logic [DATA_W-1:0]   ram_wdata,
    output logic                ram_we,
    input  logic [DATA_W-1:0]   in_port,
    output logic [DATA_W-1:0]   out_port
);

    localparam int HI_W = RAM_AW - DATA_W;

    logic [PC_W-1:0]   pc_q;
    logic [DATA_W-1:0] ir_q;
    logic [DATA_W-1:0] d_q;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] x_q;
    logic [DATA_W-1:0] y_q;
    logic [DATA_W-1:0] out_q;

    dec_t              dec;
    logic [DATA_W-1:0] bus_val;
    logic [DATA_W-1:0] alu_y;
    logic [DATA_W-1:0] addr_lo;
    logic [HI_W-1:0]   addr_hi;
    logic [PC_W-1:0]   pc_nxt;
    pcsel_e            pc_sel;

    acc8_decode u_dec (
        .opcode (ir_q),
        .dec    (dec)
    );

    always_comb begin
        unique case (dec.src)
            SRC_IMM: bus_val = d_q;
            SRC_RAM: bus_val = ram_rdata;
            SRC_ACC: bus_val = acc_q;
            SRC_INP: bus_val = in_port;
            default: bus_val = d_q;
        endcase
    end

    assign addr_lo = dec.lo_from_x ? x_q : d_q;
    assign addr_hi = dec.hi_from_y ? y_q[HI_W-1:0] : '0;

    acc8_alu #(.W(DATA_W)) u_alu (
        .op     (dec.op),
        .acc    (acc_q),
        .bus    (bus_val),
        .result (alu_y)
    );

    acc8_pc_next #(.W(DATA_W), .PC_W(PC_W)) u_pcn (
        .op     (dec.op),
        .mode   (dec.mode),
        .pc     (pc_q),
        .acc    (acc_q),
        .yr     (y_q),
        .bus    (bus_val),
        .sel    (pc_sel),
        .pc_nxt (pc_nxt)
    );

    // program counter and fetch latches
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_nxt;
        end
        ir_q <= rom_data[2*DATA_W-1:DATA_W];
        d_q  <= rom_data[DATA_W-1:0];
    end

    // architectural registers
    always_ff @(posedge clk) begin
        if (dec.dst == DST_ACC) acc_q <= alu_y;
        if (dec.dst == DST_YR)  y_q   <= alu_y;
        if (dec.dst == DST_OUT) out_q <= alu_y;
        if (dec.dst == DST_XR) begin
            x_q <= alu_y;
        end else if (dec.x_incr) begin
            x_q <= x_q + 1'b1;
        end
    end

    assign rom_addr  = pc_q;
    assign ram_addr  = {addr_hi, addr_lo};
    assign ram_wdata = bus_val;
    assign ram_we    = dec.mem_we && !rst;
    assign out_port  = out_q;

endmodule

// File: rtl/acc8_core_chk.sv
`timescale 1ns/1ps
module acc8_core_chk #(
    parameter int DATA_W = 8,
    parameter int PC_W   = 2 * DATA_W,
    parameter int RAM_AW = 15
) (
    input logic                       clk,
    input logic                       rst,
    input logic [PC_W-1:0]            rom_addr,
    input logic [RAM_AW-DATA_W-1:0]   ram_hi,
    input logic                       ram_we,
    input logic [7:2]                 ir,
    input logic [DATA_W-1:0]          acc,
    input logic [DATA_W-1:0]          xr,
    input logic [DATA_W-1:0]          yr,
    input logic [DATA_W-1:0]          outr
);

    logic is_jmp;
    logic is_st;
    assign is_jmp = (ir[7:5] == 3'd7);
    assign is_st  = (ir[7:5] == 3'd6);

    p_pc_clear_r1: assert property (@(posedge clk)
        rst |=> (rom_addr == '0));

    p_pc_step_r11: assert property (@(posedge clk) disable iff (rst)
        !is_jmp |=> (rom_addr == PC_W'($past(rom_addr) + 1'b1)));

    p_far_page_r9: assert property (@(posedge clk) disable iff (rst)
        (is_jmp && ir[4:2] == 3'd0) |=> (rom_addr[PC_W-1:DATA_W] == $past(yr)));

    p_near_page_r10: assert property (@(posedge clk) disable iff (rst)
        (is_jmp && ir[4:2] != 3'd0) |=>
            ((rom_addr[PC_W-1:DATA_W] == $past(rom_addr[PC_W-1:DATA_W])) ||
             (rom_addr == PC_W'($past(rom_addr) + 1'b1))));

    p_we_store_r7: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> is_st);

    p_xinc_r6: assert property (@(posedge clk) disable iff (rst)
        (!is_jmp && ir[4:2] == 3'd7) |=> (xr == DATA_W'($past(xr) + 1'b1)));

    p_store_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (is_st && ir[4:2] != 3'd4 && ir[4:2] != 3'd5) |=> ($stable(acc) && $stable(outr)));

    p_zero_page_r5: assert property (@(posedge clk) disable iff (rst)
        (!is_jmp && (ir[4:2] == 3'd0 || ir[4:2] == 3'd1 || ir[4:2] == 3'd4 ||
                     ir[4:2] == 3'd5 || ir[4:2] == 3'd6)) |-> (ram_hi == '0));

endmodule

bind acc8_core acc8_core_chk #(
    .DATA_W (DATA_W),
    .PC_W   (PC_W),
    .RAM_AW (RAM_AW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rom_addr (rom_addr),
    .ram_hi   (ram_addr[RAM_AW-1:DATA_W]),
    .ram_we   (ram_we),
    .ir       (ir_q[7:2]),
    .acc      (acc_q),
    .xr       (x_q),
    .yr       (y_q),
    .outr     (out_q)
);

// File: tb/tb_acc8_core.sv
`timescale 1ns/1ps
module tb_acc8_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] rom_addr;
    logic [15:0] rom_data;
    logic [14:0] ram_addr;
    logic [7:0]  ram_rdata;
    logic [7:0]  ram_wdata;
    logic        ram_we;
    logic [7:0]  in_port = 8'h3C;
    logic [7:0]  out_port;

    logic [15:0] rom_m [0:1023];
    logic [7:0]  ram_m [0:1023];

    int n_chk = 0;
    int n_bad = 0;
    bit mon_en = 1'b0;
    logic [7:0] out_prev;

    typedef struct {
        logic [14:0] a;
        logic [7:0]  v;
        string       tag;
    } st_item_t;

    typedef struct {
        logic [7:0] v;
        string      tag;
    } out_item_t;

    st_item_t  st_q[$];
    out_item_t out_q[$];

    always #2.5 clk = ~clk;

    assign rom_data  = rom_m[rom_addr[9:0]];
    assign ram_rdata = ram_m[ram_addr[9:0]];

    always @(posedge clk) begin
        if (ram_we) ram_m[ram_addr[9:0]] <= ram_wdata;
    end

    acc8_core dut (
        .clk       (clk),
        .rst       (rst),
        .rom_addr  (rom_addr),
        .rom_data  (rom_data),
        .ram_addr  (ram_addr),
        .ram_rdata (ram_rdata),
        .ram_wdata (ram_wdata),
        .ram_we    (ram_we),
        .in_port   (in_port),
        .out_port  (out_port)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic put(input int a, input logic [2:0] op, input logic [2:0] md,
                       input logic [1:0] bs, input logic [7:0] dv);
        rom_m[a] = {op, md, bs, dv};
    endtask

    task automatic exp_st(input logic [14:0] a, input logic [7:0] v, input string tag);
        st_item_t it;
        it.a = a; it.v = v; it.tag = tag;
        st_q.push_back(it);
    endtask

    task automatic exp_out(input logic [7:0] v, input string tag);
        out_item_t it;
        it.v = v; it.tag = tag;
        out_q.push_back(it);
    endtask

    task automatic clear_rom();
        for (int i = 0; i < 1024; i++) rom_m[i] = 16'h0000;
    endtask

    // reset, verify the cleared PC, then release and enable the monitor
    task automatic start_run();
        @(negedge clk);
        rst = 1'b1;
        mon_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "pc under reset", 32'(rom_addr), 32'h0);
        out_prev = out_port;
        mon_en = 1'b1;
        rst = 1'b0;
    endtask

    task automatic end_run(input int cycles);
        repeat (cycles) @(posedge clk);
        @(negedge clk);
        check("R2", "pending stores", 32'(st_q.size()), 32'h0);
        check("R6", "pending out updates", 32'(out_q.size()), 32'h0);
        mon_en = 1'b0;
        st_q.delete();
        out_q.delete();
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && mon_en) begin
            if (ram_we) begin
                if (st_q.size() == 0) begin
                    n_chk++;
                    n_bad++;
                    $display("FAIL R2 unexpected store: actual %0h<=%0h expected none",
                             ram_addr, ram_wdata);
                end else begin
                    st_item_t it;
                    it = st_q.pop_front();
                    check(it.tag, "store address", 32'(ram_addr), 32'(it.a));
                    check(it.tag, "store data", 32'(ram_wdata), 32'(it.v));
                end
            end
            if (out_port !== out_prev) begin
                if (out_q.size() == 0) begin
                    n_chk++;
                    n_bad++;
                    $display("FAIL R8 unexpected output change: actual %0h expected %0h",
                             out_port, out_prev);
                end else begin
                    out_item_t ot;
                    ot = out_q.pop_front();
                    check(ot.tag, "output register", 32'(out_port), 32'(ot.v));
                end
                out_prev = out_port;
            end
        end
    end

    task automatic load_alu_prog();
        clear_rom();
        put(0, 0, 0, 0, 8'h00);
        put(1, 0, 0, 0, 8'h5A);
        put(2, 6, 0, 2, 8'h10);   exp_st(15'h010, 8'h5A, "R3");
        put(3, 1, 0, 0, 8'h0F);
        put(4, 6, 0, 2, 8'h11);   exp_st(15'h011, 8'h0A, "R3");
        put(5, 2, 0, 0, 8'hF0);
        put(6, 6, 0, 2, 8'h12);   exp_st(15'h012, 8'hFA, "R3");
        put(7, 3, 0, 0, 8'hFF);
        put(8, 6, 0, 2, 8'h13);   exp_st(15'h013, 8'h05, "R3");
        put(9, 4, 0, 0, 8'hFE);
        put(10, 6, 0, 2, 8'h14);  exp_st(15'h014, 8'h03, "R3");
        put(11, 5, 0, 0, 8'h05);
        put(12, 6, 0, 2, 8'h15);  exp_st(15'h015, 8'hFE, "R3");
        put(13, 0, 0, 3, 8'h00);
        put(14, 6, 0, 2, 8'h16);  exp_st(15'h016, 8'h3C, "R4");
        put(15, 6, 0, 0, 8'h20);  exp_st(15'h020, 8'h20, "R4");
        put(16, 0, 0, 1, 8'h10);
        put(17, 6, 0, 2, 8'h17);  exp_st(15'h017, 8'h5A, "R4");
        put(18, 0, 4, 0, 8'h07);
        put(19, 0, 5, 0, 8'h02);
        put(20, 6, 1, 2, 8'h00);  exp_st(15'h007, 8'h5A, "R5");
        put(21, 6, 2, 2, 8'h33);  exp_st(15'h233, 8'h5A, "R5");
        put(22, 6, 3, 0, 8'h77);  exp_st(15'h207, 8'h77, "R5");
        put(23, 0, 3, 1, 8'h00);
        put(24, 0, 6, 0, 8'h81);  exp_out(8'h81, "R6");
        put(25, 0, 7, 1, 8'h00);  exp_out(8'h77, "R6");
        put(26, 6, 1, 2, 8'h00);  exp_st(15'h008, 8'h77, "R6");
        put(27, 6, 4, 0, 8'h40);  exp_st(15'h040, 8'h40, "R8");
        put(28, 6, 1, 3, 8'h00);  exp_st(15'h077, 8'h3C, "R8");
        put(29, 6, 6, 0, 8'h41);  exp_st(15'h041, 8'h41, "R8");
        put(30, 6, 0, 0, 8'h42);  exp_st(15'h042, 8'h42, "R8");
        put(31, 6, 0, 2, 8'h43);  exp_st(15'h043, 8'h77, "R8");
        put(32, 6, 5, 0, 8'h44);  exp_st(15'h044, 8'h44, "R8");
        put(33, 6, 2, 2, 8'h00);  exp_st(15'h7700, 8'h77, "R8");
        put(34, 6, 7, 0, 8'h99);  exp_st(15'h7777, 8'h99, "R6");
        put(35, 6, 1, 2, 8'h00);  exp_st(15'h078, 8'h77, "R6");
        put(36, 0, 5, 0, 8'hF1);
        put(37, 6, 2, 2, 8'h05);  exp_st(15'h7105, 8'h77, "R7");
    endtask

    task automatic load_branch_prog();
        clear_rom();
        put(12'h000, 0, 0, 0, 8'h00);
        put(12'h001, 0, 0, 0, 8'h00);
        put(12'h002, 7, 4, 0, 8'h10);
        put(12'h003, 6, 0, 2, 8'h50);
        put(12'h004, 6, 0, 0, 8'h51);
        put(12'h010, 0, 0, 0, 8'h80);
        put(12'h011, 7, 2, 0, 8'h20);
        put(12'h012, 0, 0, 0, 8'h01);
        put(12'h013, 6, 0, 0, 8'h52);
        put(12'h020, 7, 2, 0, 8'h30);
        put(12'h021, 6, 0, 2, 8'h53);
        put(12'h022, 7, 1, 0, 8'h28);
        put(12'h023, 6, 0, 0, 8'h54);
        put(12'h024, 6, 0, 0, 8'h55);
        put(12'h028, 0, 5, 0, 8'h01);
        put(12'h029, 7, 0, 0, 8'h05);
        put(12'h02A, 6, 0, 0, 8'h56);
        put(12'h02B, 6, 0, 0, 8'h57);
        put(12'h101, 0, 0, 0, 8'h00);
        put(12'h102, 7, 5, 0, 8'h80);
        put(12'h103, 6, 0, 0, 8'h59);
        put(12'h104, 6, 0, 0, 8'h5F);
        put(12'h105, 7, 7, 2, 8'h00);
        put(12'h106, 6, 0, 0, 8'h58);
        put(12'h107, 6, 0, 0, 8'h60);
        put(12'h15B, 6, 0, 0, 8'h5E);
        put(12'h180, 0, 0, 0, 8'h80);
        put(12'h181, 7, 5, 0, 8'h90);
        put(12'h182, 6, 0, 0, 8'h5A);
        put(12'h183, 6, 0, 0, 8'h5B);
        put(12'h184, 7, 0, 1, 8'h5B);
        put(12'h185, 6, 0, 0, 8'h5C);
        put(12'h186, 6, 0, 0, 8'h5D);
        exp_st(15'h050, 8'h00, "R2");   // delay slot of a taken zero test
        exp_st(15'h053, 8'h01, "R10");  // sign mask, positive AC: falls through
        exp_st(15'h054, 8'h54, "R2");   // delay slot of positive-mask jump
        exp_st(15'h056, 8'h56, "R9");   // delay slot of far jump
        exp_st(15'h058, 8'h58, "R10");  // delay slot of always-taken mask
        exp_st(15'h059, 8'h59, "R10");  // zero or positive mask, AC zero
        exp_st(15'h05A, 8'h5A, "R10");  // mask 5 with negative AC: not taken
        exp_st(15'h05B, 8'h5B, "R11");
        exp_st(15'h05C, 8'h5C, "R9");   // delay slot of far jump via memory
        exp_st(15'h05E, 8'h5E, "R9");   // landed at {Y, mem byte}
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) ram_m[i] = 8'h00;

        // ALU, bus sources, addressing modes, stores
        load_alu_prog();
        start_run();
        repeat (10) @(posedge clk);
        @(negedge clk);
        check("R11", "sequential pc", 32'(rom_addr), 32'd10);
        end_run(60);
        check("R8", "output after stores", 32'(out_port), 32'h77);

        // jumps and delay slots
        load_branch_prog();
        start_run();
        end_run(45);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule